// File: doc/BRIEF.md
# Manchester Line Transmitter with Programmable Preamble

This block turns bytes into a Manchester-coded serial line. A byte arrives on a valid/ready handshake together with three frame settings: a preamble length of 0 to 15 bit periods, a two-bit preamble pattern code and a transition polarity. The block then sends the preamble, if any, followed by the data bits least significant bit first. Every bit takes two half-bit phases, and the two phases always carry opposite levels.

A single enable input, `half_tick`, pulses once per half-bit period, so it runs at twice the bit rate. The line changes level only on edges where `half_tick` is high. When no frame is in progress the line rests low. A new byte can be accepted while the last half of the previous frame is still on the line. In that case the next frame follows with no idle gap.

Top module: `mc_line_tx`

## Requirements
- R1: After reset `line_out` is low, `busy` is low and `in_ready` is high. Whenever `busy` is low, `line_out` is low.
- R2: `in_ready` is high only when no frame is in progress, or when the second half of the last bit of the current frame is on the line. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- R3: With `cfg_pre_len` = 0 the frame has no preamble. The first half of data bit 0 is the first level sent.
- R4: With `cfg_pre_len` = L, where L is from 1 to 15, exactly L preamble bits (2L half periods) come before data bit 0.
- R5: Pattern code `cfg_pre_pat` = 2'b00 makes every preamble bit a one. Code 2'b01 makes every preamble bit a zero.
- R6: Pattern code 2'b10 makes preamble bit k equal to k mod 2, so the sequence starts with a zero. Code 2'b11 makes preamble bit k equal to 1 - (k mod 2), so the sequence starts with a one.
- R7: With `cfg_pol` = 0, a zero is sent low then high and a one is sent high then low. Preamble bits follow the same rule.
- R8: With `cfg_pol` = 1, a zero is sent high then low and a one is sent low then high.
- R9: The 8 data bits follow the preamble in order, bit 0 first. Each half period lasts from one `half_tick` edge to the next, and `line_out` changes on no other edge.
- R10: Data and all configuration inputs are sampled at the accepting edge. Changes to them later in the frame have no effect on that frame.
- R11: If no byte is accepted, the `half_tick` edge that ends the last half period drives `line_out` low. If a byte is accepted while the last half is on the line, the first half of the new frame starts at the next `half_tick` edge, with no low gap in between.
- R12: `busy` rises on the accepting edge. It stays high until the edge on which the line returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Enable pulse, one per half-bit period |
| cfg_pre_len | input | 4 | Preamble length in bit periods, 0 disables it |
| cfg_pre_pat | input | 2 | Preamble pattern code |
| cfg_pol | input | 1 | Manchester transition polarity |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken this cycle |
| line_out | output | 1 | Manchester-coded line |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest case to reach is the frame hand-off. Here a new byte is accepted in the cycle where the old frame's last half is on the line, and sometimes on the very edge that `half_tick` is high. Such an acceptance is open for only one half period, so the stimulus holds `in_valid` high through a long run of frames. It also mixes tick spacings of every cycle, every other cycle and random. Setting changes made in the middle of a frame come from reloading all settings at random on every cycle while a frame is in flight.

// File: rtl/mc_tx_pkg.sv
package mc_tx_pkg;

   typedef enum logic [1:0] {
      PAT_ONES  = 2'b00,
      PAT_ZEROS = 2'b01,
      PAT_ZO    = 2'b10,
      PAT_OZ    = 2'b11
   } pre_pat_e;

   // Preamble bit value for a given pattern and bit-index parity
   function automatic logic pre_bit(input pre_pat_e pat, input logic idx_odd);
      case (pat)
         PAT_ONES:  pre_bit = 1'b1;
         PAT_ZEROS: pre_bit = 1'b0;
         PAT_ZO:    pre_bit = idx_odd;
         default:   pre_bit = ~idx_odd;
      endcase
   endfunction

endpackage

// File: rtl/mc_tx_bitsel.sv
module mc_tx_bitsel
   import mc_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4,
   parameter int IDX_W  = 5
) (
   input  logic [LEN_W-1:0]  len,
   input  pre_pat_e          pat,
   input  logic [DATA_W-1:0] data,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_o
);

   logic              in_pre;
   logic [IDX_W-1:0]  didx;
   logic [DATA_W-1:0] hit;

   assign in_pre = idx < IDX_W'(len);
   assign didx   = idx - IDX_W'(len);

   for (genvar i = 0; i < DATA_W; i++) begin : g_dsel
      assign hit[i] = (didx == IDX_W'(i)) & data[i];
   end

   assign bit_o = in_pre ? pre_bit(pat, idx[0]) : |hit;

endmodule

// File: rtl/mc_tx_enc.sv
module mc_tx_enc (
   input  logic bit_i,
   input  logic pol,
   input  logic second_half,
   output logic level
);

   // polarity 0: zero -> low,high ; one -> high,low
   assign level = bit_i ^ pol ^ second_half;

endmodule

// File: rtl/mc_tx_seq.sv
module mc_tx_seq
   import mc_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4,
   parameter int POS_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic [LEN_W-1:0]  cfg_pre_len,
   input  pre_pat_e          cfg_pre_pat,
   input  logic              cfg_pol,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              cur_lvl,
   input  logic              first_lvl,
   output logic              in_ready,
   output logic              active,
   output logic [POS_W-1:0]  pos,
   output logic [LEN_W-1:0]  len_q,
   output pre_pat_e          pat_q,
   output logic              pol_q,
   output logic [DATA_W-1:0] data_q,
   output logic              line_q
);

   logic [POS_W-1:0] total2;
   logic             last;
   logic             accept;

   assign total2   = (POS_W'(len_q) << 1) + POS_W'(2 * DATA_W);
   assign last     = active && (pos == total2);
   assign in_ready = !active || last;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         pos    <= '0;
         len_q  <= '0;
         pat_q  <= PAT_ONES;
         pol_q  <= 1'b0;
         data_q <= '0;
         line_q <= 1'b0;
      end else if (accept) begin
         active <= 1'b1;
         len_q  <= cfg_pre_len;
         pat_q  <= cfg_pre_pat;
         pol_q  <= cfg_pol;
         data_q <= in_data;
         if (half_tick && active) begin
            line_q <= first_lvl;
            pos    <= POS_W'(1);
         end else begin
            pos    <= '0;
         end
      end else if (active && half_tick) begin
         if (last) begin
            active <= 1'b0;
            line_q <= 1'b0;
            pos    <= '0;
         end else begin
            line_q <= cur_lvl;
            pos    <= pos + POS_W'(1);
         end
      end
   end

endmodule

// File: rtl/mc_line_tx.sv
module mc_line_tx
   import mc_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              half_tick,
   input  logic [LEN_W-1:0]  cfg_pre_len,
   input  logic [1:0]        cfg_pre_pat,
   input  logic              cfg_pol,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              line_out,
   output logic              busy
);

   localparam int MAX_PRE  = (1 << LEN_W) - 1;
   localparam int MAX_BITS = MAX_PRE + DATA_W;
   localparam int POS_W    = $clog2(2 * MAX_BITS + 1);
   localparam int IDX_W    = POS_W - 1;

   if (DATA_W < 1) begin : g_bad_data
      $error("mc_line_tx: DATA_W must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("mc_line_tx: LEN_W must be 1..8");
   end

   logic              active;
   logic [POS_W-1:0]  pos;
   logic [LEN_W-1:0]  len_q;
   pre_pat_e          pat_q;
   logic              pol_q;
   logic [DATA_W-1:0] data_q;
   logic              cur_bit, first_bit;
   logic              cur_lvl, first_lvl;

   mc_tx_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .POS_W(POS_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .half_tick  (half_tick),
      .cfg_pre_len(cfg_pre_len),
      .cfg_pre_pat(pre_pat_e'(cfg_pre_pat)),
      .cfg_pol    (cfg_pol),
      .in_data    (in_data),
      .in_valid   (in_valid),
      .cur_lvl    (cur_lvl),
      .first_lvl  (first_lvl),
      .in_ready   (in_ready),
      .active     (active),
      .pos        (pos),
      .len_q      (len_q),
      .pat_q      (pat_q),
      .pol_q      (pol_q),
      .data_q     (data_q),
      .line_q     (line_out)
   );

   // bit for the half period about to be sent in the current frame
   mc_tx_bitsel #(.DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_sel_cur (
      .len  (len_q),
      .pat  (pat_q),
      .data (data_q),
      .idx  (pos[POS_W-1:1]),
      .bit_o(cur_bit)
   );

   // first bit of a frame being accepted now (gapless hand-off)
   mc_tx_bitsel #(.DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_sel_first (
      .len  (cfg_pre_len),
      .pat  (pre_pat_e'(cfg_pre_pat)),
      .data (in_data),
      .idx  ('0),
      .bit_o(first_bit)
   );

   mc_tx_enc u_enc_cur (
      .bit_i      (cur_bit),
      .pol        (pol_q),
      .second_half(pos[0]),
      .level      (cur_lvl)
   );

   mc_tx_enc u_enc_first (
      .bit_i      (first_bit),
      .pol        (cfg_pol),
      .second_half(1'b0),
      .level      (first_lvl)
   );

   assign busy = active;

endmodule

// File: rtl/mc_line_tx_chk.sv
module mc_line_tx_chk #(
   parameter int POS_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             half_tick,
   input logic             in_valid,
   input logic             in_ready,
   input logic             line_out,
   input logic             busy,
   input logic [POS_W-1:0] pos
);

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_out);                                       // R1

   AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> in_ready);                                        // R2

   AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !half_tick |=> $stable(line_out));                          // R9

   AST_MID_BIT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && half_tick && pos[0]) |=> (line_out != $past(line_out))); // R7

   AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_ready && half_tick && !in_valid) |=> (!busy && !line_out)); // R11

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !in_ready) |=> busy);                              // R12

   AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);                           // R12

endmodule

bind mc_line_tx mc_line_tx_chk #(.POS_W(POS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .half_tick(half_tick),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .line_out (line_out),
   .busy     (busy),
   .pos      (pos)
);

// File: tb/mc_line_tx_test.sv
module mc_line_tx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       half_tick = 1'b0;
   logic [3:0] cfg_pre_len = '0;
   logic [1:0] cfg_pre_pat = '0;
   logic       cfg_pol = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_valid = 1'b0;
   logic       in_ready, line_out, busy;

   int checks = 0;
   int errors = 0;

   bit    exp_q[$];
   string tag_q[$];
   bit    showing = 1'b0;
   bit    exp_line = 1'b0;
   string exp_tag = "R1";

   always #5 clk = ~clk;

   mc_line_tx uut (
      .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
      .cfg_pre_len(cfg_pre_len), .cfg_pre_pat(cfg_pre_pat), .cfg_pol(cfg_pol),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .line_out(line_out), .busy(busy)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit pat_bit(input logic [1:0] pat, input int k);
      case (pat)
         2'b00:   return 1'b1;
         2'b01:   return 1'b0;
         2'b10:   return bit'(k % 2);
         default: return bit'(1 - (k % 2));
      endcase
   endfunction

   task automatic push_frame(input logic [3:0] len, input logic [1:0] pat,
                             input logic pol, input logic [7:0] d);
      for (int k = 0; k < int'(len) + 8; k++) begin
         bit    b;
         string t;
         if (k < int'(len)) begin
            b = pat_bit(pat, k);
            t = {"R4/", (pat[1] ? "R6" : "R5"), (pol ? "/R8" : "/R7")};
         end else begin
            b = d[k - int'(len)];
            t = {"R9/R10", (len == 0 ? "/R3" : ""), (pol ? "/R8" : "/R7")};
         end
         exp_q.push_back(b ^ pol);
         tag_q.push_back(t);
         exp_q.push_back(~(b ^ pol));
         tag_q.push_back(t);
      end
   endtask

   // one clock: check outputs, drive inputs, advance the model for the next edge
   task automatic cyc(input logic v, input logic [3:0] len, input logic [1:0] pat,
                      input logic pol, input logic [7:0] d, input logic tk,
                      output bit acc);
      bit busy_was;
      @(negedge clk);
      check(exp_tag, line_out, exp_line);
      check("R12", busy, (exp_q.size() > 0) || showing);
      check("R2", in_ready, exp_q.size() == 0);
      in_valid = v; cfg_pre_len = len; cfg_pre_pat = pat; cfg_pol = pol;
      in_data = d; half_tick = tk;
      #1;
      acc = v && in_ready;
      busy_was = (exp_q.size() > 0) || showing;
      if (acc && busy_was) push_frame(len, pat, pol, d);
      if (tk) begin
         if (exp_q.size() > 0) begin
            exp_line = exp_q.pop_front();
            exp_tag  = tag_q.pop_front();
            showing  = 1'b1;
         end else begin
            exp_line = 1'b0;
            exp_tag  = "R11";
            showing  = 1'b0;
         end
      end
      if (acc && !busy_was) push_frame(len, pat, pol, d);
   endtask

   // let the current frame drain with random settings on the inputs (R10)
   task automatic drain(input bit every);
      bit a;
      int n = 0;
      while (((exp_q.size() > 0) || showing) && n < 400) begin
         cyc(1'b0, 4'($urandom), 2'($urandom), 1'($urandom), 8'($urandom),
             every ? 1'b1 : 1'($urandom % 2), a);
         n++;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit a;
      int lens[4] = '{0, 1, 2, 15};
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", line_out, 1'b0);
      check("R1", busy, 1'b0);
      check("R1", in_ready, 1'b1);

      // directed: every pattern, polarity and edge-case length
      for (int p = 0; p < 4; p++)
         for (int pl = 0; pl < 2; pl++)
            for (int li = 0; li < 4; li++) begin
               a = 1'b0;
               while (!a)
                  cyc(1'b1, 4'(lens[li]), 2'(p), 1'(pl), 8'($urandom), 1'b1, a);
               drain(1'b1);
            end

      // back-to-back frames with valid held high: gapless hand-off (R11)
      for (int i = 0; i < 3000; i++)
         cyc(1'b1, 4'($urandom % 3), 2'($urandom), 1'($urandom), 8'($urandom),
             (i % 3 == 0) ? 1'b1 : ((i % 3 == 1) ? 1'(i % 2) : 1'($urandom % 2)), a);
      drain(1'b0);

      // constrained random traffic
      for (int i = 0; i < 20000; i++) begin
         logic [3:0] l;
         case ($urandom % 4)
            0:       l = 4'd0;
            1:       l = 4'd15;
            default: l = 4'($urandom);
         endcase
         cyc(1'($urandom % 3 != 0), l, 2'($urandom), 1'($urandom), 8'($urandom),
             1'($urandom % 3 == 0), a);
      end
      drain(1'b1);

      // idle after all frames: line low, busy low (R1)
      cyc(1'b0, 4'd0, 2'd0, 1'b0, 8'd0, 1'b1, a);
      @(negedge clk);
      check("R1", line_out, 1'b0);
      check("R1", busy, 1'b0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule